// File: doc/BRIEF.md
# Write-Protected RTC Control and Alarm Front End

This block is the register front end of a real-time clock. Software reaches it over a plain 32-bit word bus with a write strobe, an address and write data. Read data returns combinationally from the address. At reset every register write is refused. Writes open only after a fixed series of seven key words lands at seven key addresses in order. Once opened, the block stays open until reset.

Behind the lock, the block holds these registers:
- a counter-freeze bit, which is exported to the calendar counter;
- a small debounce code;
- seven alarm time fields;
- an alarm control byte, which holds a master enable and a compare enable per field;
- a sticky alarm-pending flag, which software clears by writing a 1 to it.

The calendar counter supplies the current time as seven fields. Reads of the time registers return those fields. A write to a time register is passed out as a one-cycle load request, and only while the counter is frozen.

An alarm hit is detected when the alarm is enabled and every field whose compare enable is set equals the current time. A rising hit sets the pending flag. The single interrupt line is the pending flag gated by the alarm enable.

Top module: `rtc_guard_alarm`

## Requirements
- R1: The write lock opens after these writes, in this order: 0xC6 to 0x04, 0x9A to 0x08, 0x59 to 0x0C, 0xA3 to 0x10, 0x57 to 0x14, 0x67 to 0x18 and 0xD2 to 0x1C. Each value is compared as the full 32-bit word. Once open, the lock stays open until reset, whatever is written afterwards.
- R2: While locked, a write to any key address (0x04..0x1C) that is not the next expected address and value returns the key tracker to its first step. Writes to other addresses leave the tracker where it is.
- R3: While locked, writes to 0x20, 0x2C, 0x30 and 0x60..0x7C change nothing. Writes to the time registers raise no load request.
- R4: Register 0x20, bit 0, is the counter-freeze bit. It resets to 1, reads back, and drives `cnt_stop_o`.
- R5: Register 0x2C holds a 3-bit debounce code in bits 2:0. It resets to 0 and drives `debounce_o`. Higher write bits are dropped and read as 0.
- R6: Words 0x40 + 4·i, for i = 0..6 (year, month, day of month, day of week, hour, minute, second), read the current-time field i. Field i sits in bits [8·i+7 : 8·i] of `cal_time_i`.
- R7: When the block is unlocked and the freeze bit is 1, a write to 0x40 + 4·i raises `tm_wr_o` in that cycle, with `tm_field_o` = i and `tm_value_o` = wdata[7:0]. When the freeze bit is 0, no load request is raised.
- R8: Words 0x60 + 4·i hold alarm field i, in the same order as R6. Each field is 8 bits wide and resets to 0.
- R9: Register 0x7C is the alarm control byte and resets to 0. Bit 0 is the alarm enable. Bit 7−i enables the compare of field i, so bit 1 is second and bit 7 is year. A hit holds when bit 0 is 1 and every enabled field equals its current-time field.
- R10: Register 0x30, bit 4, is the pending flag. It is set at the clock edge after a hit first becomes true, and it then holds. Writing 1 to bit 4 clears it. Writing 0 to bit 4 has no effect.
- R11: `alarm_irq_o` is the pending flag ANDed with the alarm enable. Clearing the enable drops the line but leaves the flag set.
- R12: Unmapped, misaligned and key addresses read as 0, and so do all register bits that are not defined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| cal_time_i | input | 56 | Current time, seven 8-bit fields, year in the lowest byte |
| cnt_stop_o | output | 1 | Counter freeze |
| debounce_o | output | 3 | Debounce code |
| tm_wr_o | output | 1 | Time-field load request |
| tm_field_o | output | 3 | Index of the field to load (0 = year) |
| tm_value_o | output | 8 | Value to load |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions assume that the current-time inputs and the bus inputs change only between clock edges. They also assume that a pending-flag rise can only follow a registered hit, which holds only if `cal_time_i` is driven by synchronous logic and not by glitching paths. The stimulus respects this by driving every input at the falling edge and holding it over the following rising edge. The sticky-flag property treats any write of bit 4 to 0x30 as a possible clear, whether or not the lock is open, so it never depends on the order in which software unlocks and acknowledges.

// File: rtl/rtcg_pkg.sv
// Shared constants for the write-protected RTC front end.
// Assumes an 8-bit byte address space with word-aligned registers.
package rtcg_pkg;
    localparam int NUM_FIELDS   = 7;
    localparam int UNLOCK_LEN   = 7;
    localparam int CTL_W        = NUM_FIELDS + 1;
    localparam int PEND_BIT     = 4;
    localparam logic [7:0] OFS_CTRL  = 8'h20;
    localparam logic [7:0] OFS_DEB   = 8'h2C;
    localparam logic [7:0] OFS_INT   = 8'h30;
    localparam logic [7:0] OFS_TIME  = 8'h40;
    localparam logic [7:0] OFS_ALM   = 8'h60;
    localparam logic [7:0] OFS_ALCTL = 8'h7C;
    localparam logic [7:0] KEY_LO    = 8'h04;
    localparam logic [7:0] KEY_HI    = 8'h1C;

    // Key value expected at a given step of the unlock series
    function automatic logic [7:0] key_word(input logic [2:0] step);
        case (step)
            3'd0:    return 8'hC6;
            3'd1:    return 8'h9A;
            3'd2:    return 8'h59;
            3'd3:    return 8'hA3;
            3'd4:    return 8'h57;
            3'd5:    return 8'h67;
            default: return 8'hD2;
        endcase
    endfunction

    // Key address expected at a given step: one word per step from 0x04
    function automatic logic [7:0] key_addr(input logic [2:0] step);
        return {3'b000, step + 3'd1, 2'b00};
    endfunction
endpackage

// File: rtl/rtcg_unlock.sv
// Key-series tracker. It opens the register write lock after the full
// series of key words arrives in order. Assumes one bus write per cycle
// at most. Once open, the lock stays open until reset.
module rtcg_unlock
    import rtcg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              unlocked_o
);
    localparam logic [2:0] LAST_STEP = 3'(UNLOCK_LEN - 1);

    logic [2:0] step_q;
    logic       open_q;
    logic       in_keys;
    logic       key_ok;

    // Decode: is this write aimed at the key window, and is it the next key
    always_comb begin
        in_keys = (addr_i >= ADDR_W'(KEY_LO)) && (addr_i <= ADDR_W'(KEY_HI))
                  && (addr_i[1:0] == 2'b00);
        key_ok  = (addr_i == ADDR_W'(key_addr(step_q)))
                  && (wdata_i == DATA_W'(key_word(step_q)));
    end

    // Step the tracker on good keys, restart it on bad ones, latch open at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            open_q <= 1'b0;
        end else if (wr_i && !open_q && in_keys) begin
            if (key_ok) begin
                if (step_q == LAST_STEP) begin
                    open_q <= 1'b1;
                    step_q <= '0;
                end else begin
                    step_q <= step_q + 3'd1;
                end
            end else begin
                step_q <= '0;
            end
        end
    end

    assign unlocked_o = open_q;
endmodule

// File: rtl/rtcg_regs.sv
// Register file and address decode. It holds the freeze bit, the debounce
// code, the alarm fields and the alarm control byte. It forms the
// time-load request and the pending-clear pulse, and builds the read data.
// Assumes FIELD_W >= CTL_W, FIELD_W > PEND_BIT and FIELD_W >= DEB_W.
module rtcg_regs
    import rtcg_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 8,
    parameter int DEB_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic                          unlocked_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] cal_time_i,
    input  logic                          status_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic                          stop_o,
    output logic [DEB_W-1:0]              deb_o,
    output logic [NUM_FIELDS*FIELD_W-1:0] alm_fields_o,
    output logic [CTL_W-1:0]              alm_ctl_o,
    output logic                          status_clr_o,
    output logic                          tm_wr_o,
    output logic [2:0]                    tm_field_o,
    output logic [FIELD_W-1:0]            tm_value_o
);
    logic                  stop_q;
    logic [DEB_W-1:0]      deb_q;
    logic [CTL_W-1:0]      alctl_q;
    logic [FIELD_W-1:0]    alm_q [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] tsel;
    logic [NUM_FIELDS-1:0] asel;
    logic                  wr_ok;
    logic                  hit_ctrl, hit_deb, hit_int, hit_alctl;
    logic [2:0]            tm_idx;
    logic                  unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:FIELD_W];

    // Writes count only once the key series has opened the lock
    assign wr_ok     = wr_i && unlocked_i;
    assign hit_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
    assign hit_deb   = (addr_i == ADDR_W'(OFS_DEB));
    assign hit_int   = (addr_i == ADDR_W'(OFS_INT));
    assign hit_alctl = (addr_i == ADDR_W'(OFS_ALCTL));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
            // Per-field word selects for the time and alarm banks
            assign tsel[gi] = (addr_i == ADDR_W'(OFS_TIME) + ADDR_W'(4 * gi));
            assign asel[gi] = (addr_i == ADDR_W'(OFS_ALM) + ADDR_W'(4 * gi));

            // Alarm field storage, written through its own word
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alm_q[gi] <= '0;
                else if (wr_ok && asel[gi])
                    alm_q[gi] <= wdata_i[FIELD_W-1:0];
            end

            assign alm_fields_o[gi*FIELD_W +: FIELD_W] = alm_q[gi];
        end
    endgenerate

    // Scalar control registers: freeze, debounce, alarm control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q  <= 1'b1;
            deb_q   <= '0;
            alctl_q <= '0;
        end else if (wr_ok) begin
            if (hit_ctrl)  stop_q  <= wdata_i[0];
            if (hit_deb)   deb_q   <= wdata_i[DEB_W-1:0];
            if (hit_alctl) alctl_q <= wdata_i[CTL_W-1:0];
        end
    end

    // Encode which time field a load request targets
    always_comb begin
        tm_idx = '0;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (tsel[i]) tm_idx = 3'(i);
    end

    assign tm_wr_o      = wr_ok && stop_q && (|tsel);
    assign tm_field_o   = tm_idx;
    assign tm_value_o   = wdata_i[FIELD_W-1:0];
    assign status_clr_o = wr_ok && hit_int && wdata_i[PEND_BIT];

    // Read data mux; anything unselected returns zero
    always_comb begin
        rdata_o = '0;
        if (hit_ctrl)  rdata_o[0]          = stop_q;
        if (hit_deb)   rdata_o[DEB_W-1:0]  = deb_q;
        if (hit_int)   rdata_o[PEND_BIT]   = status_i;
        if (hit_alctl) rdata_o[CTL_W-1:0]  = alctl_q;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (tsel[i]) rdata_o[FIELD_W-1:0] = cal_time_i[i*FIELD_W +: FIELD_W];
            if (asel[i]) rdata_o[FIELD_W-1:0] = alm_q[i];
        end
    end

    assign stop_o    = stop_q;
    assign deb_o     = deb_q;
    assign alm_ctl_o = alctl_q;
endmodule

// File: rtl/rtcg_alarm.sv
// Alarm comparator and pending flag. It compares each field whose compare
// enable is set and qualifies the result with the master enable. The flag
// is set on a rising hit and cleared by a pulse; set wins over clear.
// Assumes cal_time_i is synchronous to clk.
module rtcg_alarm
    import rtcg_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_FIELDS*FIELD_W-1:0] cal_time_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] alm_fields_i,
    input  logic [CTL_W-1:0]              alm_ctl_i,
    input  logic                          clr_i,
    output logic                          hit_o,
    output logic                          status_o,
    output logic                          irq_o
);
    logic [NUM_FIELDS-1:0] fld_ok;
    logic                  hit_q;
    logic                  pend_q;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
            // A field passes when its compare is off or its values agree
            assign fld_ok[gi] = !alm_ctl_i[NUM_FIELDS - gi]
                || (cal_time_i[gi*FIELD_W +: FIELD_W] == alm_fields_i[gi*FIELD_W +: FIELD_W]);
        end
    endgenerate

    assign hit_o = alm_ctl_i[0] && (&fld_ok);

    // Edge-detect the hit and hold the pending flag until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            hit_q <= hit_o;
            if (hit_o && !hit_q)
                pend_q <= 1'b1;
            else if (clr_i)
                pend_q <= 1'b0;
        end
    end

    assign status_o = pend_q;
    assign irq_o    = pend_q && alm_ctl_i[0];
endmodule

// File: rtl/rtc_guard_alarm.sv
// Top level of the write-protected RTC front end. It ties the key
// tracker, the register file and the alarm logic together. The timekeeping
// counter lives outside; it supplies cal_time_i and accepts tm_wr_o loads.
module rtc_guard_alarm
    import rtcg_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 8,
    parameter int DEB_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr_i,
    input  logic [ADDR_W-1:0]             bus_addr_i,
    input  logic [DATA_W-1:0]             bus_wdata_i,
    output logic [DATA_W-1:0]             bus_rdata_o,
    input  logic [NUM_FIELDS*FIELD_W-1:0] cal_time_i,
    output logic                          cnt_stop_o,
    output logic [DEB_W-1:0]              debounce_o,
    output logic                          tm_wr_o,
    output logic [2:0]                    tm_field_o,
    output logic [FIELD_W-1:0]            tm_value_o,
    output logic                          alarm_irq_o
);
    logic                          unlocked;
    logic                          status;
    logic                          status_clr;
    logic                          hit;
    logic [CTL_W-1:0]              alm_ctl;
    logic [NUM_FIELDS*FIELD_W-1:0] alm_fields;

    rtcg_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_unlock (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .unlocked_o (unlocked)
    );

    rtcg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .DEB_W(DEB_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (bus_wr_i),
        .addr_i       (bus_addr_i),
        .wdata_i      (bus_wdata_i),
        .unlocked_i   (unlocked),
        .cal_time_i   (cal_time_i),
        .status_i     (status),
        .rdata_o      (bus_rdata_o),
        .stop_o       (cnt_stop_o),
        .deb_o        (debounce_o),
        .alm_fields_o (alm_fields),
        .alm_ctl_o    (alm_ctl),
        .status_clr_o (status_clr),
        .tm_wr_o      (tm_wr_o),
        .tm_field_o   (tm_field_o),
        .tm_value_o   (tm_value_o)
    );

    rtcg_alarm #(.FIELD_W(FIELD_W)) u_alarm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_time_i   (cal_time_i),
        .alm_fields_i (alm_fields),
        .alm_ctl_i    (alm_ctl),
        .clr_i        (status_clr),
        .hit_o        (hit),
        .status_o     (status),
        .irq_o        (alarm_irq_o)
    );
endmodule

// File: rtl/rtcg_chk.sv
// Property checker for rtc_guard_alarm, attached by bind. It observes the
// bus, the lock state, the pending flag, the hit and the interrupt.
module rtcg_chk
    import rtcg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              unlocked,
    input logic              stop,
    input logic              status,
    input logic              hit,
    input logic              alm_en,
    input logic              irq,
    input logic              tm_wr
);
    logic maybe_clr;
    assign maybe_clr = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_INT)) && bus_wdata_i[PEND_BIT];

    // R1: once open, the lock never closes again
    a_r1_lock_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

    // R3: while locked, the freeze bit cannot move
    a_r3_locked_stop_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(stop));

    // R7: time loads only when unlocked and frozen
    a_r7_load_needs_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        tm_wr |-> (stop && unlocked));

    // R10: the pending flag rises only after a hit
    a_r10_rise_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(hit));

    // R10: the pending flag holds unless a clear write arrives
    a_r10_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !maybe_clr) |=> status);

    // R11: no interrupt with the alarm disabled
    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !alm_en |-> !irq);

    // R11: an interrupt always has a pending flag behind it
    a_r11_irq_has_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status);
endmodule

bind rtc_guard_alarm rtcg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .unlocked    (unlocked),
    .stop        (cnt_stop_o),
    .status      (status),
    .hit         (hit),
    .alm_en      (alm_ctl[0]),
    .irq         (alarm_irq_o),
    .tm_wr       (tm_wr_o)
);

// File: tb/tb_rtc_guard_alarm.sv
// Self-checking bench: unlock paths, register sweeps, full address read
// sweep and per-field alarm matching against a bench-side model.
module tb_rtc_guard_alarm;
    localparam int NF = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NF*8-1:0] cal_flat;
    logic        cnt_stop;
    logic [2:0]  debounce;
    logic        tm_wr;
    logic [2:0]  tm_field;
    logic [7:0]  tm_value;
    logic        irq;

    logic [7:0]  cal [NF];
    logic [7:0]  m_alm [NF];
    logic        m_stop;
    logic [2:0]  m_deb;
    logic        m_pend;
    logic [7:0]  m_alctl;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    // Pack the bench's current-time array into the flat input
    always_comb begin
        for (int i = 0; i < NF; i++) cal_flat[i*8 +: 8] = cal[i];
    end

    rtc_guard_alarm dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .cal_time_i(cal_flat),
        .cnt_stop_o(cnt_stop), .debounce_o(debounce), .tm_wr_o(tm_wr),
        .tm_field_o(tm_field), .tm_value_o(tm_value), .alarm_irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] v = '0;
        if (a == 8'h20) v = {31'd0, m_stop};
        if (a == 8'h2C) v = {29'd0, m_deb};
        if (a == 8'h30) v = {27'd0, m_pend, 4'd0};
        if (a == 8'h7C) v = {24'd0, m_alctl};
        for (int i = 0; i < NF; i++) begin
            if (a == 8'(8'h40 + 4 * i)) v = {24'd0, cal[i]};
            if (a == 8'(8'h60 + 4 * i)) v = {24'd0, m_alm[i]};
        end
        return v;
    endfunction

    function automatic logic [7:0] key_v(input int s);
        case (s)
            0: return 8'hC6; 1: return 8'h9A; 2: return 8'h59; 3: return 8'hA3;
            4: return 8'h57; 5: return 8'h67; default: return 8'hD2;
        endcase
    endfunction

    task automatic key(input int s);
        wr(8'(4 * (s + 1)), {24'd0, key_v(s)});
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NF; i++) begin cal[i] = 8'(8'h21 + 3 * i); m_alm[i] = '0; end
        m_stop = 1'b1; m_deb = '0; m_pend = 1'b0; m_alctl = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R4, R5, R10, R11)
        rd(8'h20, d); chk("R4 reset freeze", d, 32'd1);
        chk("R4 reset cnt_stop_o", {31'd0, cnt_stop}, 32'd1);
        chk("R5 reset debounce_o", {29'd0, debounce}, 32'd0);
        rd(8'h30, d); chk("R10 reset pending", d, 32'd0);
        chk("R11 reset irq", {31'd0, irq}, 32'd0);

        // R3: writes while locked change nothing
        wr(8'h20, 32'd0); wr(8'h2C, 32'd7); wr(8'h60, 32'hAA); wr(8'h7C, 32'hFF);
        bus_wr = 1'b1; bus_addr = 8'h44; bus_wdata = 32'h5; #1;
        chk("R3 locked time load", {31'd0, tm_wr}, 32'd0);
        tick(); bus_wr = 1'b0;
        rd(8'h20, d); chk("R3 locked freeze", d, 32'd1);
        rd(8'h2C, d); chk("R3 locked debounce", d, 32'd0);
        rd(8'h60, d); chk("R3 locked alarm field", d, 32'd0);
        rd(8'h7C, d); chk("R3 locked alarm ctl", d, 32'd0);

        // R2: wrong value mid-series restarts the tracker
        for (int s = 0; s < 3; s++) key(s);
        wr(8'h10, 32'h00);
        for (int s = 3; s < 7; s++) key(s);
        wr(8'h2C, 32'd3); rd(8'h2C, d); chk("R2 bad value keeps lock", d, 32'd0);
        // R2: a skipped step restarts the tracker
        key(0); key(1); key(3); key(4); key(5); key(6);
        wr(8'h2C, 32'd3); rd(8'h2C, d); chk("R2 skipped step keeps lock", d, 32'd0);
        // R2: a full-word mismatch (upper bits set) is a bad key
        key(0); wr(8'h08, 32'h0000_019A);
        for (int s = 2; s < 7; s++) key(s);
        wr(8'h2C, 32'd3); rd(8'h2C, d); chk("R2 upper bits keep lock", d, 32'd0);

        // R1 and R2: full series with a foreign write in the middle opens the lock
        for (int s = 0; s < 3; s++) key(s);
        wr(8'h2C, 32'd6);
        for (int s = 3; s < 7; s++) key(s);
        rd(8'h2C, d); chk("R3 write before open ignored", d, 32'd0);
        wr(8'h2C, 32'd5); m_deb = 3'd5;
        rd(8'h2C, d); chk("R1 open after series", d, 32'd5);
        // R1: a bad key after opening does not relock
        wr(8'h04, 32'h0); wr(8'h2C, 32'd2); m_deb = 3'd2;
        rd(8'h2C, d); chk("R1 lock stays open", d, 32'd2);

        // R5 sweep with junk in the upper bits
        for (int v = 0; v < 16; v++) begin
            wr(8'h2C, 32'hFFFF_FFF0 | 32'(v)); m_deb = 3'(v);
            rd(8'h2C, d); chk("R5 debounce readback", d, {29'd0, 3'(v)});
            chk("R5 debounce_o", {29'd0, debounce}, {29'd0, 3'(v)});
        end

        // R4 and R7: time loads are blocked while running
        wr(8'h20, 32'hFFFF_FFFE); m_stop = 1'b0;
        chk("R4 cnt_stop_o cleared", {31'd0, cnt_stop}, 32'd0);
        for (int i = 0; i < NF; i++) begin
            bus_wr = 1'b1; bus_addr = 8'(8'h40 + 4 * i); bus_wdata = 32'(8'h30 + i); #1;
            chk("R7 no load while running", {31'd0, tm_wr}, 32'd0);
            tick(); bus_wr = 1'b0;
        end
        wr(8'h20, 32'd1); m_stop = 1'b1;
        for (int i = 0; i < NF; i++) begin
            bus_wr = 1'b1; bus_addr = 8'(8'h40 + 4 * i); bus_wdata = 32'hFFFF_FF00 | 32'(8'h30 + i); #1;
            chk("R7 load strobe", {31'd0, tm_wr}, 32'd1);
            chk("R7 load field", {29'd0, tm_field}, 32'(i));
            chk("R7 load value", {24'd0, tm_value}, 32'(8'h30 + i));
            tick(); bus_wr = 1'b0;
        end

        // R8: alarm fields hold only their low byte
        for (int i = 0; i < NF; i++) begin
            wr(8'(8'h60 + 4 * i), 32'hFFFF_FF00 | 32'(8'h10 + i)); m_alm[i] = 8'(8'h10 + i);
        end

        // R6, R8, R12: full read sweep against the model
        for (int a = 0; a < 256; a++) begin
            rd(8'(a), d); chk("R12 R6 R8 read sweep", d, exp_rd(8'(a)));
        end

        // R9, R10, R11: one compare enable at a time
        for (int i = 0; i < NF; i++) cal[i] = 8'h00;
        for (int i = 0; i < NF; i++) begin
            m_alctl = 8'h01 | 8'(1 << (7 - i));
            wr(8'h7C, {24'd0, m_alctl});
            tick();
            rd(8'h30, d); chk("R9 enabled field mismatch blocks", d, 32'd0);
            cal[i] = m_alm[i];
            tick();
            rd(8'h30, d); chk("R10 pending set one edge after hit", d, 32'h10);
            chk("R11 irq with enable", {31'd0, irq}, 32'd1);
            wr(8'h30, 32'h10);
            rd(8'h30, d); chk("R10 write-one clears", d, 32'd0);
            chk("R11 irq dropped after clear", {31'd0, irq}, 32'd0);
            cal[i] = 8'h00;
        end

        // R9: all fields equal but master enable off, then on
        for (int i = 0; i < NF; i++) cal[i] = m_alm[i];
        m_alctl = 8'hFE; wr(8'h7C, 32'hFE); tick();
        rd(8'h30, d); chk("R9 no hit without enable", d, 32'd0);
        m_alctl = 8'hFF; wr(8'h7C, 32'hFF);
        rd(8'h30, d); chk("R10 pending not yet set", d, 32'd0);
        tick();
        rd(8'h30, d); chk("R9 all-field hit", d, 32'h10);
        wr(8'h30, 32'hFFFF_FFEF);
        rd(8'h30, d); chk("R10 write of zero keeps pending", d, 32'h10);
        m_alctl = 8'h00; wr(8'h7C, 32'h0);
        chk("R11 irq off when disabled", {31'd0, irq}, 32'd0);
        rd(8'h30, d); chk("R11 pending kept when disabled", d, 32'h10);
        wr(8'h30, 32'h10);
        rd(8'h30, d); chk("R10 final clear", d, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule